// File: doc/BRIEF.md
# Serial Receive Channel with Status Queue and Flow Control

This block is the receive half of an asynchronous serial port. It watches one serial input line and is paced by an enable pulse at sixteen times the bit rate. It checks each start bit at its centre, then takes 5 to 8 data bits with the least significant bit first. An optional parity or address/data bit may follow, and then a stop bit. Each finished character goes into a four-entry queue, together with three status bits: received break, framing error, and parity error. In multidrop mode the third status bit holds the address/data tag instead of a parity error.

Software-side logic reads the character at the head of the queue from `rd_data` and removes it with `rd_en`. The status outputs can describe only the head character. They can instead collect the status of every character that has reached the head since the last error-clear pulse. A character that arrives while the queue is full is dropped, and a sticky overrun flag is set. When receiver flow control is on, the active-low ready-to-send output is raised if a new start bit is validated while the queue is full. It is lowered again as soon as a queue slot frees. A single request output follows either "data available" or "queue full", as selected.

Top module: `uart_rx_channel`

## Requirements
- R1: `cfg_len` sets the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Bits arrive least significant first, and the unused upper bits of `rd_data` read as zero.
- R2: A low level is taken as a start bit only if the line is still low at the centre of the bit, eight ticks after the low level is first seen. A shorter low pulse produces no character.
- R3: With `cfg_pmode`=00, one parity bit follows the data. `st_pe` is set when the number of ones in the data and the parity bit together is odd while `cfg_ptype`=0 (even parity), or even while `cfg_ptype`=1 (odd parity).
- R4: With `cfg_pmode`=01, the extra bit must equal `cfg_ptype`, and `st_pe` is set otherwise. With `cfg_pmode`=10, no extra bit is received and `st_pe` stays 0.
- R5: With `cfg_pmode`=11 (multidrop), the extra bit is stored in the `st_pe` position: 1 marks an address and 0 marks data. The status outputs then use the per-character reporting of R8 even when `cfg_blk_err`=1.
- R6: A low stop bit sets `st_fe`. If the data, the extra bit and the stop bit are all low, `st_rb` is also set. After a low stop bit, the receiver waits for the line to go high before it looks for a new start bit.
- R7: The queue holds 4 characters in arrival order. `rx_rdy` is 1 while it holds at least one character, and `fifo_full` is 1 while it holds 4.
- R8: With `cfg_blk_err`=0, `st_rb`, `st_fe` and `st_pe` show only the head character, and they are 0 while the queue is empty.
- R9: With `cfg_blk_err`=1 and no multidrop, the status outputs are the OR of the current head's status and the status of every earlier head seen since the last `err_clr` pulse. `err_clr` clears that history.
- R10: A character completed while the queue is full is discarded without changing the queue. `st_ovr` then reads 1 until an `err_clr` pulse clears it.
- R11: When `cfg_rts_en`=1, `rts_n` goes high if a start bit is validated while the queue is full, and returns low one cycle after the queue is no longer full. When `cfg_rts_en`=0, `rts_n` stays low.
- R12: `irq_req` follows `rx_rdy` when `cfg_irq_sel`=0 and follows `fifo_full` when `cfg_irq_sel`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Enable pulse at 16x the bit rate |
| rxd | input | 1 | Serial input line, idle high |
| cfg_len | input | 2 | Data bit count select |
| cfg_pmode | input | 2 | Parity mode: check, forced, none, multidrop |
| cfg_ptype | input | 1 | Parity type or forced level |
| cfg_blk_err | input | 1 | Accumulated (block) status reporting |
| cfg_rts_en | input | 1 | Receiver flow control enable |
| cfg_irq_sel | input | 1 | Request source: 0 data available, 1 queue full |
| err_clr | input | 1 | Clears status history and overrun |
| rd_en | input | 1 | Removes the head character |
| rd_data | output | 8 | Head character |
| st_rb | output | 1 | Received break |
| st_fe | output | 1 | Framing error |
| st_pe | output | 1 | Parity error or address/data tag |
| st_ovr | output | 1 | Sticky overrun |
| rx_rdy | output | 1 | Queue not empty |
| fifo_full | output | 1 | Queue full |
| irq_req | output | 1 | Interrupt/DMA request |
| rts_n | output | 1 | Active-low ready-to-send |

## Verification
The hardest case to reach is a start bit that arrives while the queue already holds four characters. Only that case raises `rts_n` and, at the stop bit, drops the character into overrun. The bench sends four frames without reading, then sends a fifth with flow control on. It checks that `rts_n` is high, `st_ovr` is set and the original head is unchanged. A single read must then lower `rts_n` again. Block-mode history is reached by queueing a bad character ahead of a good one, removing the bad one, and checking that its error is still visible until `err_clr`.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam logic [1:0] PM_CHECK = 2'b00;
    localparam logic [1:0] PM_FORCE = 2'b01;
    localparam logic [1:0] PM_NONE  = 2'b10;
    localparam logic [1:0] PM_MULTI = 2'b11;

    typedef struct packed {
        logic brk;
        logic ferr;
        logic perr;
    } rx_flags_t;

    typedef struct packed {
        logic [7:0] data;
        rx_flags_t  flags;
    } rx_char_t;

    typedef enum logic [2:0] {
        FS_IDLE, FS_START, FS_DATA, FS_PAR, FS_STOP, FS_HOLD
    } frame_state_e;

    function automatic logic [3:0] data_bits(input logic [1:0] code);
        return 4'd5 + {2'b00, code};
    endfunction

    function automatic logic extra_flag(input logic [1:0] pm, input logic pt,
                                        input logic [7:0] d, input logic pb);
        case (pm)
            PM_CHECK: return ((^d) ^ pb) != pt;
            PM_FORCE: return pb != pt;
            PM_MULTI: return pb;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OS_RATE = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rxd,
    input  logic [1:0] cfg_len,
    input  logic [1:0] cfg_pmode,
    input  logic       cfg_ptype,
    output logic       start_ok,
    output logic       char_vld,
    output rx_char_t   char_out
);
    localparam int CW = $clog2(OS_RATE);
    localparam logic [CW-1:0] MID  = CW'(OS_RATE / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OS_RATE - 1);

    frame_state_e  state;
    logic [CW-1:0] cnt;
    logic [2:0]    idx;
    logic [7:0]    shreg;
    logic          pbit;
    logic [3:0]    nbits;

    assign nbits = data_bits(cfg_len);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= FS_IDLE;
            cnt      <= '0;
            idx      <= '0;
            shreg    <= '0;
            pbit     <= 1'b0;
            start_ok <= 1'b0;
            char_vld <= 1'b0;
            char_out <= '0;
        end else begin
            start_ok <= 1'b0;
            char_vld <= 1'b0;
            if (tick) begin
                case (state)
                    FS_IDLE: begin
                        if (!rxd) begin
                            state <= FS_START;
                            cnt   <= '0;
                        end
                    end
                    FS_START: begin
                        if (cnt == MID) begin
                            cnt <= '0;
                            if (!rxd) begin
                                state    <= FS_DATA;
                                start_ok <= 1'b1;
                                idx      <= '0;
                                shreg    <= '0;
                                pbit     <= 1'b0;
                            end else begin
                                state <= FS_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    FS_DATA: begin
                        if (cnt == LAST) begin
                            cnt        <= '0;
                            shreg[idx] <= rxd;
                            if ({1'b0, idx} == nbits - 4'd1)
                                state <= (cfg_pmode == PM_NONE) ? FS_STOP : FS_PAR;
                            else
                                idx <= idx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    FS_PAR: begin
                        if (cnt == LAST) begin
                            cnt   <= '0;
                            pbit  <= rxd;
                            state <= FS_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    FS_STOP: begin
                        if (cnt == LAST) begin
                            cnt                 <= '0;
                            char_vld            <= 1'b1;
                            char_out.data       <= shreg;
                            char_out.flags.ferr <= !rxd;
                            char_out.flags.brk  <= !rxd && (shreg == 8'h00) && !pbit;
                            char_out.flags.perr <= extra_flag(cfg_pmode, cfg_ptype, shreg, pbit);
                            state               <= rxd ? FS_IDLE : FS_HOLD;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    FS_HOLD: begin
                        if (rxd) state <= FS_IDLE;
                    end
                    default: state <= FS_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  rx_char_t                   wdata,
    input  logic                       pop,
    output rx_char_t                   rdata,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       empty,
    output logic                       full
);
    localparam int AW   = $clog2(DEPTH);
    localparam int CNTW = $clog2(DEPTH + 1);
    localparam logic [CNTW-1:0] DEPTH_C = CNTW'(DEPTH);

    rx_char_t        mem [DEPTH];
    logic [AW-1:0]   wptr, rptr;

    assign empty = (count == '0);
    assign full  = (count == DEPTH_C);
    assign rdata = mem[rptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (push) begin
                mem[wptr] <= wdata;
                wptr      <= wptr + 1'b1;
            end
            if (pop) rptr <= rptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      blk_mode,
    input  logic      head_vld,
    input  rx_flags_t head_flags,
    input  logic      clr,
    input  logic      drop,
    output rx_flags_t flags,
    output logic      ovr
);
    rx_flags_t acc;
    rx_flags_t head_now;

    assign head_now = head_vld ? head_flags : '0;
    assign flags    = blk_mode ? (acc | head_now) : head_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
            ovr <= 1'b0;
        end else begin
            if (clr)           acc <= '0;
            else if (blk_mode) acc <= acc | head_now;
            if (clr)           ovr <= 1'b0;
            else if (drop)     ovr <= 1'b1;
        end
    end
endmodule

// File: rtl/uart_rx_channel.sv
module uart_rx_channel
    import uart_rx_pkg::*;
#(
    parameter int OS_RATE = 16,
    parameter int DEPTH   = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick16,
    input  logic       rxd,
    input  logic [1:0] cfg_len,
    input  logic [1:0] cfg_pmode,
    input  logic       cfg_ptype,
    input  logic       cfg_blk_err,
    input  logic       cfg_rts_en,
    input  logic       cfg_irq_sel,
    input  logic       err_clr,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic       st_rb,
    output logic       st_fe,
    output logic       st_pe,
    output logic       st_ovr,
    output logic       rx_rdy,
    output logic       fifo_full,
    output logic       irq_req,
    output logic       rts_n
);
    localparam int CNTW = $clog2(DEPTH + 1);

    logic            start_ok, char_vld, push, pop, drop, empty, blk_eff;
    rx_char_t        new_char, head;
    rx_flags_t       flags;
    logic [CNTW-1:0] fifo_cnt;

    uart_rx_frame #(.OS_RATE(OS_RATE)) u_frame (
        .clk(clk), .rst(rst), .tick(tick16), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_pmode(cfg_pmode), .cfg_ptype(cfg_ptype),
        .start_ok(start_ok), .char_vld(char_vld), .char_out(new_char)
    );

    assign push = char_vld && !fifo_full;
    assign drop = char_vld && fifo_full;
    assign pop  = rd_en && !empty;

    uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(push), .wdata(new_char), .pop(pop),
        .rdata(head), .count(fifo_cnt), .empty(empty), .full(fifo_full)
    );

    assign blk_eff = cfg_blk_err && (cfg_pmode != PM_MULTI);

    uart_rx_status u_status (
        .clk(clk), .rst(rst), .blk_mode(blk_eff), .head_vld(!empty),
        .head_flags(head.flags), .clr(err_clr), .drop(drop),
        .flags(flags), .ovr(st_ovr)
    );

    assign rd_data = head.data;
    assign st_rb   = flags.brk;
    assign st_fe   = flags.ferr;
    assign st_pe   = flags.perr;
    assign rx_rdy  = !empty;
    assign irq_req = cfg_irq_sel ? fifo_full : rx_rdy;

    always_ff @(posedge clk) begin
        if (rst)                        rts_n <= 1'b0;
        else if (!cfg_rts_en)           rts_n <= 1'b0;
        else if (start_ok && fifo_full) rts_n <= 1'b1;
        else if (!fifo_full)            rts_n <= 1'b0;
    end
endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk #(
    parameter int DEPTH = 4
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       cfg_rts_en,
    input logic                       cfg_blk_err,
    input logic [1:0]                 cfg_pmode,
    input logic                       err_clr,
    input logic                       rx_rdy,
    input logic                       fifo_full,
    input logic                       rts_n,
    input logic                       st_ovr,
    input logic                       st_rb,
    input logic                       st_fe,
    input logic                       st_pe,
    input logic [$clog2(DEPTH+1)-1:0] fifo_cnt
);
    localparam int CNTW = $clog2(DEPTH + 1);
    localparam logic [CNTW-1:0] DEPTH_C = CNTW'(DEPTH);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) fifo_cnt <= DEPTH_C); // R7
    AST_FULL_HAS_DATA: assert property (@(posedge clk) disable iff (rst) fifo_full |-> rx_rdy); // R7
    AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!rx_rdy && !(cfg_blk_err && cfg_pmode != 2'b11)) |-> !(st_rb || st_fe || st_pe)); // R8
    AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (rst) err_clr |=> !st_ovr); // R10
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst) (st_ovr && !err_clr) |=> st_ovr); // R10
    AST_RTS_FULL_ONLY: assert property (@(posedge clk) disable iff (rst) $rose(rts_n) |-> $past(fifo_full)); // R11
    AST_RTS_RELEASE: assert property (@(posedge clk) disable iff (rst) (rts_n && !fifo_full) |=> !rts_n); // R11
    AST_RTS_DISABLED: assert property (@(posedge clk) disable iff (rst) !cfg_rts_en |=> !rts_n); // R11
endmodule

bind uart_rx_channel uart_rx_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .cfg_rts_en(cfg_rts_en), .cfg_blk_err(cfg_blk_err),
    .cfg_pmode(cfg_pmode), .err_clr(err_clr), .rx_rdy(rx_rdy), .fifo_full(fifo_full),
    .rts_n(rts_n), .st_ovr(st_ovr), .st_rb(st_rb), .st_fe(st_fe), .st_pe(st_pe),
    .fifo_cnt(fifo_cnt)
);

// File: tb/uart_rx_channel_tb.sv
module uart_rx_channel_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick16 = 1'b1;
    logic rxd = 1'b1;
    logic [1:0] cfg_len = 2'b11;
    logic [1:0] cfg_pmode = 2'b10;
    logic cfg_ptype = 1'b0, cfg_blk_err = 1'b0, cfg_rts_en = 1'b0, cfg_irq_sel = 1'b0;
    logic err_clr = 1'b0, rd_en = 1'b0;
    logic [7:0] rd_data;
    logic st_rb, st_fe, st_pe, st_ovr, rx_rdy, fifo_full, irq_req, rts_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    uart_rx_channel u_dut (
        .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd), .cfg_len(cfg_len),
        .cfg_pmode(cfg_pmode), .cfg_ptype(cfg_ptype), .cfg_blk_err(cfg_blk_err),
        .cfg_rts_en(cfg_rts_en), .cfg_irq_sel(cfg_irq_sel), .err_clr(err_clr),
        .rd_en(rd_en), .rd_data(rd_data), .st_rb(st_rb), .st_fe(st_fe), .st_pe(st_pe),
        .st_ovr(st_ovr), .rx_rdy(rx_rdy), .fifo_full(fifo_full), .irq_req(irq_req),
        .rts_n(rts_n)
    );

    typedef struct packed {
        logic [1:0] len;
        logic [1:0] pm;
        logic       pt;
        logic [7:0] d;
        logic       pb;
        logic       stp;
        logic [7:0] xd;
        logic       xrb;
        logic       xfe;
        logic       xpe;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{2'b11, 2'b10, 1'b0, 8'hA5, 1'b0, 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0},
        '{2'b11, 2'b00, 1'b0, 8'h03, 1'b0, 1'b1, 8'h03, 1'b0, 1'b0, 1'b0},
        '{2'b11, 2'b00, 1'b0, 8'h07, 1'b0, 1'b1, 8'h07, 1'b0, 1'b0, 1'b1},
        '{2'b11, 2'b00, 1'b1, 8'h07, 1'b0, 1'b1, 8'h07, 1'b0, 1'b0, 1'b0},
        '{2'b00, 2'b10, 1'b0, 8'hFF, 1'b0, 1'b1, 8'h1F, 1'b0, 1'b0, 1'b0},
        '{2'b01, 2'b01, 1'b1, 8'h2A, 1'b0, 1'b1, 8'h2A, 1'b0, 1'b0, 1'b1},
        '{2'b10, 2'b01, 1'b0, 8'h55, 1'b0, 1'b1, 8'h55, 1'b0, 1'b0, 1'b0},
        '{2'b11, 2'b11, 1'b0, 8'h80, 1'b1, 1'b1, 8'h80, 1'b0, 1'b0, 1'b1},
        '{2'b11, 2'b10, 1'b0, 8'h10, 1'b0, 1'b0, 8'h10, 1'b0, 1'b1, 1'b0},
        '{2'b11, 2'b10, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0},
        '{2'b10, 2'b00, 1'b1, 8'hFF, 1'b0, 1'b1, 8'h7F, 1'b0, 1'b0, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hold_bit();
        repeat (16) @(negedge clk);
    endtask

    task automatic send(input logic [1:0] len, input logic [1:0] pm, input logic [7:0] d,
                        input logic pb, input logic stp);
        int nb;
        nb = 5 + int'(len);
        rxd = 1'b0;
        hold_bit();
        for (int i = 0; i < nb; i++) begin
            rxd = d[i];
            hold_bit();
        end
        if (pm != 2'b10) begin
            rxd = pb;
            hold_bit();
        end
        rxd = stp;
        hold_bit();
        rxd = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic pop();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_clr();
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_cfg(input logic [1:0] len, input logic [1:0] pm, input logic pt);
        cfg_len = len;
        cfg_pmode = pm;
        cfg_ptype = pt;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Reset state (R7 R8 R10 R11 R12)
        check("R7 reset rx_rdy", rx_rdy, 0);
        check("R7 reset fifo_full", fifo_full, 0);
        check("R8 reset flags", {st_rb, st_fe, st_pe}, 0);
        check("R10 reset ovr", st_ovr, 0);
        check("R11 reset rts_n", rts_n, 0);
        check("R12 reset irq", irq_req, 0);

        // Vector table: length (R1), parity (R3 R4), multidrop tag (R5), stop/break (R6)
        for (int v = 0; v < NV; v++) begin
            set_cfg(VECS[v].len, VECS[v].pm, VECS[v].pt);
            send(VECS[v].len, VECS[v].pm, VECS[v].d, VECS[v].pb, VECS[v].stp);
            check("R7 vector rx_rdy", rx_rdy, 1);
            check("R1 vector data", rd_data, VECS[v].xd);
            check("R6 vector break", st_rb, VECS[v].xrb);
            check("R6 vector framing", st_fe, VECS[v].xfe);
            check("R3 R4 R5 vector parity flag", st_pe, VECS[v].xpe);
            pop();
            check("R8 vector empty after read", {rx_rdy, st_rb, st_fe, st_pe}, 0);
        end

        // R2: short low pulse is not a start bit
        set_cfg(2'b11, 2'b10, 1'b0);
        rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (200) @(negedge clk);
        check("R2 glitch ignored", rx_rdy, 0);
        send(2'b11, 2'b10, 8'h3C, 1'b0, 1'b1);
        check("R2 frame after glitch", rd_data, 8'h3C);
        // R12 with one character
        cfg_irq_sel = 1'b0;
        @(negedge clk);
        check("R12 irq follows rx_rdy", irq_req, 1);
        cfg_irq_sel = 1'b1;
        @(negedge clk);
        check("R12 irq follows full (not full)", irq_req, 0);
        pop();

        // R7 R10 R11: fill, overrun, flow control
        cfg_rts_en = 1'b1;
        for (int k = 0; k < 4; k++) send(2'b11, 2'b10, 8'h11 * (k + 1), 1'b0, 1'b1);
        check("R7 full after four", fifo_full, 1);
        check("R12 irq on full", irq_req, 1);
        check("R11 rts low before start", rts_n, 0);
        send(2'b11, 2'b10, 8'hEE, 1'b0, 1'b1);
        check("R11 rts high after start while full", rts_n, 1);
        check("R10 overrun set", st_ovr, 1);
        check("R10 head unchanged", rd_data, 8'h11);
        pop();
        check("R11 rts released after read", rts_n, 0);
        check("R10 overrun sticky", st_ovr, 1);
        for (int k = 1; k < 4; k++) begin
            check("R7 order", rd_data, 8'h11 * (k + 1));
            pop();
        end
        check("R7 empty after drain", rx_rdy, 0);
        pulse_clr();
        check("R10 overrun cleared", st_ovr, 0);

        // R11 disabled: full queue with start bit keeps rts low
        cfg_rts_en = 1'b0;
        for (int k = 0; k < 5; k++) send(2'b11, 2'b10, 8'h40 + 8'(k), 1'b0, 1'b1);
        check("R11 rts stays low when disabled", rts_n, 0);
        for (int k = 0; k < 4; k++) pop();
        pulse_clr();
        cfg_irq_sel = 1'b0;

        // R9 block mode accumulation
        cfg_blk_err = 1'b1;
        set_cfg(2'b11, 2'b00, 1'b0);
        send(2'b11, 2'b00, 8'h07, 1'b0, 1'b1);
        send(2'b11, 2'b00, 8'h03, 1'b0, 1'b1);
        check("R9 head error shown", st_pe, 1);
        pop();
        check("R9 good head", rd_data, 8'h03);
        check("R9 earlier error held", st_pe, 1);
        pulse_clr();
        check("R9 cleared by err_clr", st_pe, 0);
        pop();

        // R5 multidrop forces per-character status
        set_cfg(2'b11, 2'b11, 1'b0);
        send(2'b11, 2'b11, 8'h41, 1'b1, 1'b1);
        send(2'b11, 2'b11, 8'h42, 1'b0, 1'b1);
        check("R5 address tag", st_pe, 1);
        pop();
        check("R5 data tag after address", st_pe, 0);
        pop();
        cfg_blk_err = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule